// File: doc/BRIEF.md
# Vector Register Group Legality Checker

This block decides whether the register operands of one vector instruction form legal register groups under the current grouping configuration. It takes the group-multiplier code, the element-width code, an operation class and a masked flag, together with the 5-bit base indices of the destination and up to two sources. From these it computes an effective group size for each operand, tests that size against the legal range, tests that each base index is aligned to it, and tests the mask-register conflict on the destination.

The result is an illegal-instruction flag, a 3-bit cause code for each operand, and the position of the first failing operand. A decode stage uses these to raise an exception or to let the instruction issue. The result is registered once by default. A parameter removes that register and gives a purely combinational path. Decode, execution and operand overlap rules other than the mask conflict are outside this block.

Top module: `vrg_legality_check`

## Requirements
- R1: The multiplier code decodes as 000=1, 001=2, 010=4, 011=8, 111=1/2, 110=1/4 and 101=1/8 registers. In the plain class (opClass 00, and the unused 11) every operand uses the group size equal to the multiplier. With element-width codes 0xx, a plain operation that is unmasked and uses multiplier 1 is always legal.
- R2: Multiplier code 100 is reserved. Every used operand then reports cause 1.
- R3: An operand whose effective group size is 2, 4 or 8 and whose base index is not a multiple of that size reports cause 6.
- R4: An operand with a fractional effective group size occupies one register, and any base index is aligned for it.
- R5: In the widening class (opClass 01) the destination and the first source (vs2) use twice the multiplier, and the second source (vs1) uses the multiplier. An effective size above 8 reports cause 4, so widening with multiplier 8 fails on the destination and on vs2.
- R6: In the fixed-width class (opClass 10) the destination uses EEW×multiplier/SEW, and both sources use the multiplier. A result above 8 reports cause 4. A result below 1/8 reports cause 5.
- R7: The SEW and EEW codes are 000=8, 001=16, 010=32 and 011=64 bits. An SEW code of 1xx gives cause 2 on every used operand. An EEW code of 1xx gives cause 3, but only in the fixed-width class; in the other classes the EEW code is ignored.
- R8: When masked is high and the destination group contains v0 (base index 0, at any size), the destination reports cause 7.
- R9: Each operand reports only its highest-priority cause. The order is 1, 2, 3, then 4 or 5, then 6, then 7.
- R10: A source whose use flag is low reports cause 0 and never makes the instruction illegal.
- R11: illegal is high exactly when some operand cause is nonzero. firstBad gives the first failing operand in the order vd=1, vs2=2, vs1=3, and 0 when none fails.
- R12: With REG_OUT=1 the outputs follow the inputs one clock edge later. While rstN is low they read illegal=0, all causes 0 and firstBad=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| lmulCode | input | 3 | Group multiplier code |
| sewCode | input | 3 | Selected element width code |
| eewCode | input | 3 | Element width carried by a fixed-width operation |
| opClass | input | 2 | 00 plain, 01 widening, 10 fixed-width, 11 as plain |
| masked | input | 1 | Operation uses v0 as its mask |
| vdIdx | input | 5 | Destination base register index |
| vs2Idx | input | 5 | First source base register index |
| vs1Idx | input | 5 | Second source base register index |
| useVs2 | input | 1 | First source is present |
| useVs1 | input | 1 | Second source is present |
| illegal | output | 1 | Instruction is illegal |
| vdCause | output | 3 | Destination cause code |
| vs2Cause | output | 3 | First source cause code |
| vs1Cause | output | 3 | Second source cause code |
| firstBad | output | 2 | First failing operand, 0 for none |

## Verification
The plain-class patterns place aligned and misaligned bases on each operand in turn. This separates the per-operand alignment masks and shows that the first-failure position follows operand order. The widening and fixed-width patterns use one index set under several multipliers and width ratios, so a wrong doubling or a wrong ratio shows up as a wrong cause on only the operand it should touch. Stacked faults, such as a reserved code, an oversized group and a v0 destination together, pin down the priority. Inputs with the source use flags low, and an EEW code outside the fixed-width class, show that ignored inputs leave every output at zero.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
  localparam int OPS    = 3;
  localparam int LOGW   = 5;
  localparam int FBW    = $clog2(OPS + 1);
  localparam int MAXLOG = 3;
  localparam int MINLOG = -3;

  typedef enum logic [2:0] {
    CZ_OK    = 3'd0,
    CZ_LMUL  = 3'd1,
    CZ_SEW   = 3'd2,
    CZ_EEW   = 3'd3,
    CZ_BIG   = 3'd4,
    CZ_SMALL = 3'd5,
    CZ_ALIGN = 3'd6,
    CZ_MASK  = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_WIDEN = 2'd1,
    OP_EEW   = 2'd2,
    OP_SPARE = 2'd3
  } opclass_e;

  typedef struct packed {
    cause_e                     cfgCause;
    logic                       maskOn;
    logic [OPS-1:0][LOGW-1:0]   emulLog;
  } strobe_t;
endpackage

// File: rtl/vrg_ctrl.sv
module vrg_ctrl
  import vrg_pkg::*;
(
  input  logic [2:0] lmulCode,
  input  logic [2:0] sewCode,
  input  logic [2:0] eewCode,
  input  logic [1:0] opClass,
  input  logic       masked,
  output strobe_t    stb
);
  logic signed [LOGW-1:0] lmulLog;
  logic signed [LOGW-1:0] sewLog;
  logic signed [LOGW-1:0] eewLog;
  logic signed [LOGW-1:0] wideLog;
  logic signed [LOGW-1:0] dataLog;
  logic                   lmulBad;
  logic                   sewBad;
  logic                   eewBad;
  opclass_e               cls;

  assign cls = opclass_e'(opClass);

  // multiplier code to log2 of group size
  always_comb begin
    lmulBad = 1'b0;
    case (lmulCode)
      3'b000:  lmulLog = LOGW'(0);
      3'b001:  lmulLog = LOGW'(1);
      3'b010:  lmulLog = LOGW'(2);
      3'b011:  lmulLog = LOGW'(3);
      3'b111:  lmulLog = LOGW'(-1);
      3'b110:  lmulLog = LOGW'(-2);
      3'b101:  lmulLog = LOGW'(-3);
      default: begin
        lmulLog = LOGW'(0);
        lmulBad = 1'b1;
      end
    endcase
  end

  always_comb begin
    sewLog  = $signed(LOGW'(sewCode[1:0]));
    eewLog  = $signed(LOGW'(eewCode[1:0]));
    sewBad  = sewCode[2];
    eewBad  = (cls == OP_EEW) && eewCode[2];
    wideLog = lmulLog + LOGW'(1);
    dataLog = lmulLog + eewLog - sewLog;
  end

  always_comb begin
    if (lmulBad)     stb.cfgCause = CZ_LMUL;
    else if (sewBad) stb.cfgCause = CZ_SEW;
    else if (eewBad) stb.cfgCause = CZ_EEW;
    else             stb.cfgCause = CZ_OK;
    stb.maskOn = masked;
    case (cls)
      OP_WIDEN: begin
        stb.emulLog[0] = wideLog;
        stb.emulLog[1] = wideLog;
      end
      OP_EEW: begin
        stb.emulLog[0] = dataLog;
        stb.emulLog[1] = lmulLog;
      end
      default: begin
        stb.emulLog[0] = lmulLog;
        stb.emulLog[1] = lmulLog;
      end
    endcase
    stb.emulLog[2] = lmulLog;
  end
endmodule

// File: rtl/vrg_dp.sv
module vrg_dp
  import vrg_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  strobe_t                     stb,
  input  logic [OPS-1:0][IDX_W-1:0]   idxVec,
  input  logic [OPS-1:0]              useVec,
  output logic [OPS-1:0][2:0]         causeVec,
  output logic                        illegal,
  output logic [FBW-1:0]              firstBad
);
  for (genvar g = 0; g < OPS; g++) begin : gOp
    logic signed [LOGW-1:0] eLog;
    logic [IDX_W-1:0]       lowMask;
    logic                   misal;
    logic                   coversV0;
    cause_e                 c;

    always_comb begin
      eLog = stb.emulLog[g];
      lowMask = '0;
      for (int b = 0; b < IDX_W; b++) begin
        if (b < int'(eLog)) lowMask[b] = 1'b1;
      end
      misal    = |(idxVec[g] & lowMask);
      coversV0 = (g == 0) && stb.maskOn && (idxVec[g] == '0);
    end

    always_comb begin
      if (!useVec[g])                   c = CZ_OK;
      else if (stb.cfgCause != CZ_OK)   c = stb.cfgCause;
      else if (int'(eLog) > MAXLOG)     c = CZ_BIG;
      else if (int'(eLog) < MINLOG)     c = CZ_SMALL;
      else if (misal)                   c = CZ_ALIGN;
      else if (coversV0)                c = CZ_MASK;
      else                              c = CZ_OK;
    end

    assign causeVec[g] = c;
  end

  always_comb begin
    firstBad = '0;
    illegal  = 1'b0;
    for (int i = OPS - 1; i >= 0; i--) begin
      if (causeVec[i] != 3'd0) begin
        firstBad = FBW'(i + 1);
        illegal  = 1'b1;
      end
    end
  end

  // R11: a failing instruction always names an operand
  always_comb begin
    if (illegal) begin
      p_first_named_r11: assert (firstBad != '0);
    end
  end
endmodule

// File: rtl/vrg_legality_check.sv
module vrg_legality_check
  import vrg_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       lmulCode,
  input  logic [2:0]       sewCode,
  input  logic [2:0]       eewCode,
  input  logic [1:0]       opClass,
  input  logic             masked,
  input  logic [IDX_W-1:0] vdIdx,
  input  logic [IDX_W-1:0] vs2Idx,
  input  logic [IDX_W-1:0] vs1Idx,
  input  logic             useVs2,
  input  logic             useVs1,
  output logic             illegal,
  output logic [2:0]       vdCause,
  output logic [2:0]       vs2Cause,
  output logic [2:0]       vs1Cause,
  output logic [1:0]       firstBad
);
  strobe_t                   stb;
  logic [OPS-1:0][IDX_W-1:0] idxVec;
  logic [OPS-1:0]            useVec;
  logic [OPS-1:0][2:0]       causeVec;
  logic                      illNext;
  logic [FBW-1:0]            firstNext;

  assign idxVec = {vs1Idx, vs2Idx, vdIdx};
  assign useVec = {useVs1, useVs2, 1'b1};

  vrg_ctrl u_ctrl (
    .lmulCode (lmulCode),
    .sewCode  (sewCode),
    .eewCode  (eewCode),
    .opClass  (opClass),
    .masked   (masked),
    .stb      (stb)
  );

  vrg_dp #(.IDX_W(IDX_W)) u_dp (
    .stb      (stb),
    .idxVec   (idxVec),
    .useVec   (useVec),
    .causeVec (causeVec),
    .illegal  (illNext),
    .firstBad (firstNext)
  );

  if (REG_OUT) begin : gReg
    logic pastValid;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        illegal   <= 1'b0;
        vdCause   <= 3'd0;
        vs2Cause  <= 3'd0;
        vs1Cause  <= 3'd0;
        firstBad  <= 2'd0;
        pastValid <= 1'b0;
      end else begin
        illegal   <= illNext;
        vdCause   <= causeVec[0];
        vs2Cause  <= causeVec[1];
        vs1Cause  <= causeVec[2];
        firstBad  <= 2'(firstNext);
        pastValid <= 1'b1;
      end
    end

    p_plain_m1_r1: assert property (@(posedge clk) disable iff (!rstN)
      pastValid && $past(lmulCode) == 3'b000 && $past(opClass) == 2'd0 &&
      !$past(sewCode[2]) && !$past(masked) |-> !illegal);

    p_reserved_lmul_r2: assert property (@(posedge clk) disable iff (!rstN)
      pastValid && $past(lmulCode) == 3'b100 |-> illegal && vdCause == 3'd1);

    p_odd_misalign_r3: assert property (@(posedge clk) disable iff (!rstN)
      pastValid && $past(lmulCode) == 3'b001 && $past(opClass) == 2'd0 &&
      !$past(sewCode[2]) && $past(vdIdx[0]) |-> vdCause == 3'd6);

    p_frac_free_r4: assert property (@(posedge clk) disable iff (!rstN)
      pastValid && $past(lmulCode) == 3'b111 && $past(opClass) == 2'd0 &&
      !$past(sewCode[2]) && !$past(masked) |-> !illegal);

    p_widen_m8_r5: assert property (@(posedge clk) disable iff (!rstN)
      pastValid && $past(lmulCode) == 3'b011 && $past(opClass) == 2'd1 &&
      !$past(sewCode[2]) |-> vdCause == 3'd4 && vs2Cause == 3'd4);

    p_mask_v0_r8: assert property (@(posedge clk) disable iff (!rstN)
      pastValid && $past(masked) && $past(vdIdx) == '0 |-> illegal);
  end else begin : gComb
    assign illegal  = illNext;
    assign vdCause  = causeVec[0];
    assign vs2Cause = causeVec[1];
    assign vs1Cause = causeVec[2];
    assign firstBad = 2'(firstNext);
  end
endmodule

// File: tb/sim_vrg_legality_check.sv
module sim_vrg_legality_check;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] lmulCode = '0, sewCode = '0, eewCode = '0;
  logic [1:0] opClass = '0;
  logic       masked = 1'b0;
  logic [4:0] vdIdx = '0, vs2Idx = '0, vs1Idx = '0;
  logic       useVs2 = 1'b1, useVs1 = 1'b1;
  logic       illegal;
  logic [2:0] vdCause, vs2Cause, vs1Cause;
  logic [1:0] firstBad;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  vrg_legality_check u0 (
    .clk(clk), .rstN(rstN), .lmulCode(lmulCode), .sewCode(sewCode),
    .eewCode(eewCode), .opClass(opClass), .masked(masked),
    .vdIdx(vdIdx), .vs2Idx(vs2Idx), .vs1Idx(vs1Idx),
    .useVs2(useVs2), .useVs1(useVs1), .illegal(illegal),
    .vdCause(vdCause), .vs2Cause(vs2Cause), .vs1Cause(vs1Cause),
    .firstBad(firstBad)
  );

  task automatic chk(string tag, logic eI, logic [2:0] eD, logic [2:0] e2,
                     logic [2:0] e1, logic [1:0] eF);
    total++;
    if (illegal !== eI || vdCause !== eD || vs2Cause !== e2 ||
        vs1Cause !== e1 || firstBad !== eF) begin
      bad++;
      $display("FAIL %s: got ill=%0d causes=%0d/%0d/%0d first=%0d exp ill=%0d causes=%0d/%0d/%0d first=%0d",
               tag, illegal, vdCause, vs2Cause, vs1Cause, firstBad,
               eI, eD, e2, e1, eF);
    end
  endtask

  task automatic drive(logic [2:0] lm, logic [2:0] sw, logic [2:0] ew,
                       logic [1:0] cl, logic mk, logic [4:0] d,
                       logic [4:0] s2, logic [4:0] s1, logic u2, logic u1);
    @(negedge clk);
    lmulCode = lm; sewCode = sw; eewCode = ew; opClass = cl; masked = mk;
    vdIdx = d; vs2Idx = s2; vs1Idx = s1; useVs2 = u2; useVs1 = u1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 reset state", 0, 0, 0, 0, 0);
    rstN = 1'b1;
    drive(3'b000, 3'b010, 3'b000, 2'd0, 0, 5'd1, 5'd2, 5'd3, 1, 1);
    chk("R12 legal after reset", 0, 0, 0, 0, 0);
    // latency: new illegal input is not visible before the next edge
    @(negedge clk);
    lmulCode = 3'b100;
    #1;
    chk("R12 output held before edge", 0, 0, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R12 output after edge", 1, 1, 1, 1, 1);
    rstN = 1'b0;
    #1;
    chk("R12 reset clears outputs", 0, 0, 0, 0, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_plain;
    drive(3'b010, 3'b010, 3'b000, 2'd0, 0, 5'd4, 5'd8, 5'd12, 1, 1);
    chk("R1 m4 aligned", 0, 0, 0, 0, 0);
    drive(3'b010, 3'b010, 3'b000, 2'd0, 0, 5'd4, 5'd6, 5'd12, 1, 1);
    chk("R3 R11 vs2 misaligned m4", 1, 0, 6, 0, 2);
    drive(3'b011, 3'b010, 3'b000, 2'd0, 0, 5'd8, 5'd16, 5'd24, 1, 1);
    chk("R1 m8 aligned", 0, 0, 0, 0, 0);
    drive(3'b011, 3'b010, 3'b000, 2'd0, 0, 5'd8, 5'd16, 5'd20, 1, 1);
    chk("R3 R11 vs1 misaligned m8", 1, 0, 0, 6, 3);
    drive(3'b001, 3'b000, 3'b000, 2'd0, 0, 5'd5, 5'd8, 5'd12, 1, 1);
    chk("R3 vd v5 at m2", 1, 6, 0, 0, 1);
    drive(3'b001, 3'b000, 3'b000, 2'd0, 0, 5'd5, 5'd7, 5'd12, 1, 1);
    chk("R11 first of two failures", 1, 6, 6, 0, 1);
  endtask

  task automatic t_frac;
    drive(3'b111, 3'b001, 3'b000, 2'd0, 0, 5'd5, 5'd7, 5'd31, 1, 1);
    chk("R4 half odd bases", 0, 0, 0, 0, 0);
    drive(3'b101, 3'b011, 3'b000, 2'd0, 0, 5'd3, 5'd9, 5'd17, 1, 1);
    chk("R4 eighth odd bases", 0, 0, 0, 0, 0);
  endtask

  task automatic t_reserved;
    drive(3'b100, 3'b010, 3'b000, 2'd0, 0, 5'd0, 5'd0, 5'd0, 1, 1);
    chk("R2 reserved code", 1, 1, 1, 1, 1);
    drive(3'b100, 3'b010, 3'b000, 2'd0, 0, 5'd0, 5'd0, 5'd0, 1, 0);
    chk("R2 R10 reserved vs1 unused", 1, 1, 1, 0, 1);
  endtask

  task automatic t_widen;
    drive(3'b001, 3'b001, 3'b000, 2'd1, 0, 5'd4, 5'd8, 5'd2, 1, 1);
    chk("R5 widen m2 aligned", 0, 0, 0, 0, 0);
    drive(3'b001, 3'b001, 3'b000, 2'd1, 0, 5'd2, 5'd8, 5'd2, 1, 1);
    chk("R5 widen vd needs 4", 1, 6, 0, 0, 1);
    drive(3'b001, 3'b001, 3'b000, 2'd1, 0, 5'd4, 5'd8, 5'd3, 1, 1);
    chk("R5 widen vs1 keeps 2", 1, 0, 0, 6, 3);
    drive(3'b011, 3'b001, 3'b000, 2'd1, 0, 5'd0, 5'd16, 5'd8, 1, 1);
    chk("R5 widen m8 too big", 1, 4, 4, 0, 1);
    drive(3'b111, 3'b001, 3'b000, 2'd1, 0, 5'd3, 5'd5, 5'd7, 1, 1);
    chk("R5 widen half gives one", 0, 0, 0, 0, 0);
  endtask

  task automatic t_eew;
    drive(3'b000, 3'b000, 3'b010, 2'd2, 0, 5'd4, 5'd1, 5'd3, 1, 1);
    chk("R6 eew32 sew8 m1 at v4", 0, 0, 0, 0, 0);
    drive(3'b000, 3'b000, 3'b010, 2'd2, 0, 5'd2, 5'd1, 5'd3, 1, 1);
    chk("R6 eew32 sew8 m1 at v2", 1, 6, 0, 0, 1);
    drive(3'b101, 3'b011, 3'b000, 2'd2, 0, 5'd1, 5'd1, 5'd3, 1, 1);
    chk("R6 below eighth", 1, 5, 0, 0, 1);
    drive(3'b011, 3'b000, 3'b011, 2'd2, 0, 5'd0, 5'd8, 5'd16, 1, 1);
    chk("R6 above eight", 1, 4, 0, 0, 1);
    drive(3'b000, 3'b011, 3'b000, 2'd2, 0, 5'd7, 5'd1, 5'd3, 1, 1);
    chk("R6 exactly eighth", 0, 0, 0, 0, 0);
  endtask

  task automatic t_codes;
    drive(3'b000, 3'b100, 3'b000, 2'd0, 0, 5'd1, 5'd2, 5'd3, 1, 1);
    chk("R7 bad sew", 1, 2, 2, 2, 1);
    drive(3'b100, 3'b101, 3'b000, 2'd0, 0, 5'd1, 5'd2, 5'd3, 1, 1);
    chk("R9 lmul before sew", 1, 1, 1, 1, 1);
    drive(3'b000, 3'b010, 3'b110, 2'd2, 0, 5'd0, 5'd2, 5'd3, 1, 1);
    chk("R7 bad eew fixed class", 1, 3, 3, 3, 1);
    drive(3'b000, 3'b010, 3'b110, 2'd0, 0, 5'd1, 5'd2, 5'd3, 1, 1);
    chk("R7 eew ignored plain", 0, 0, 0, 0, 0);
  endtask

  task automatic t_mask;
    drive(3'b010, 3'b010, 3'b000, 2'd0, 1, 5'd0, 5'd4, 5'd8, 1, 1);
    chk("R8 masked vd v0 m4", 1, 7, 0, 0, 1);
    drive(3'b010, 3'b010, 3'b000, 2'd0, 1, 5'd4, 5'd0, 5'd8, 1, 1);
    chk("R8 masked vd v4 m4", 0, 0, 0, 0, 0);
    drive(3'b010, 3'b010, 3'b000, 2'd0, 0, 5'd0, 5'd4, 5'd8, 1, 1);
    chk("R8 unmasked vd v0", 0, 0, 0, 0, 0);
    drive(3'b111, 3'b010, 3'b000, 2'd0, 1, 5'd0, 5'd1, 5'd2, 1, 1);
    chk("R8 masked fractional v0", 1, 7, 0, 0, 1);
    drive(3'b100, 3'b010, 3'b000, 2'd0, 1, 5'd0, 5'd1, 5'd2, 1, 1);
    chk("R9 reserved over mask", 1, 1, 1, 1, 1);
    drive(3'b011, 3'b010, 3'b000, 2'd1, 1, 5'd0, 5'd0, 5'd8, 1, 1);
    chk("R9 too big over mask", 1, 4, 4, 0, 1);
  endtask

  task automatic t_unused;
    drive(3'b010, 3'b010, 3'b000, 2'd0, 0, 5'd4, 5'd1, 5'd3, 0, 0);
    chk("R10 unused misaligned sources", 0, 0, 0, 0, 0);
    drive(3'b010, 3'b010, 3'b000, 2'd0, 0, 5'd4, 5'd1, 5'd3, 0, 1);
    chk("R10 vs1 used again", 1, 0, 0, 6, 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_frac();
    t_reserved();
    t_widen();
    t_eew();
    t_codes();
    t_mask();
    t_unused();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule